// File: doc/BRIEF.md
# Sixteen-Pin GPIO Bank with Interrupt Detection

This block is one bank of sixteen general-purpose pins, controlled through a small 32-bit register port. Each register is selected by a byte address and has a write strobe, write data and combinational read data. Each pin can be set up in four ways:

- as an output, driving a registered value through the output-enable and output-value signals;
- as an input, whose synchronised level can be read back;
- as an interrupt source, with edge or level sensing, a choice of one edge or both edges, and a choice of polarity;
- with a per-pin access mask that limits which bits a data write may change and which bits a data read returns.

Raw and masked interrupt status can be read. Software acknowledges latched edges by writing ones to the acknowledge register. A single registered interrupt line reports whether any unmasked pin is pending.

Pad inputs pass through a two-flop synchroniser. Edge detection then compares the current synchronised sample with the previous one. Each pin's edge latch is a two-state machine:

- **DET_IDLE**: nothing is latched. It leaves on the ARM transition, which fires when the selected edge is seen.
- **DET_HELD**: an edge is latched. It returns to DET_IDLE on the RELEASE transition, which fires when an acknowledge bit is written and no new edge arrives in the same cycle.

The bank has 32-bit registers but only the low 16 bits are live. The register offsets are:

| Offset | Register | Access |
|---|---|---|
| 0x00 | data | read/write |
| 0x04 | access mask | read/write |
| 0x08 | direction | read/write |
| 0x0C | sense (1 = level) | read/write |
| 0x10 | both-edge select | read/write |
| 0x14 | polarity | read/write |
| 0x18 | interrupt enable | read/write |
| 0x1C | raw status | read-only |
| 0x20 | masked status | read-only |
| 0x24 | acknowledge | write-only |
| 0x28 | input enable | read/write |

Top module: `pinbank_irq`

## Requirements
- R1: After reset, every register reads 0, and `pad_oe`, `pad_out` and `irq_out` are 0.
- R2: Read data bits 31:16 are always 0. The acknowledge register (0x24) reads 0. Writes to raw status (0x1C) and masked status (0x20) change nothing.
- R3: Direction bit 1 makes the pin an output, and `pad_oe` equals the direction register. A direction write that turns a pin into an output clears its input-enable bit. A write that turns it into an input sets that bit. Pins whose direction does not change keep their input-enable bit.
- R4: A data write (0x00) changes `pad_out` only on pins whose access-mask bit (0x04) is 1.
- R5: A data read returns the synchronised pad level ANDed with input enable and access mask. A pad change becomes visible after the second rising clock edge.
- R6: With sense 0 and both-edge 0, polarity 1 latches a rising edge and polarity 0 latches a falling edge into raw status.
- R7: With sense 0 and both-edge 1, either edge latches raw status, whatever the polarity.
- R8: With sense 1, the raw status bit follows the pad level: directly when polarity is 1, inverted when polarity is 0. It is not latched, and acknowledge does not change it.
- R9: Writing 1 to an acknowledge bit clears that pin's latched edge. Writing 0 does nothing. An edge arriving in the same cycle as the acknowledge leaves the bit set.
- R10: Masked status equals raw status ANDed with interrupt enable. `irq_out` is the OR of masked status, registered one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 6 | Byte address of the register |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from the address |
| pad_in | input | 16 | Pad input levels, asynchronous |
| pad_oe | output | 16 | Output enable per pin |
| pad_out | output | 16 | Output value per pin |
| irq_out | output | 1 | Combined interrupt |

## Verification
The bench sweeps every combination of sense, both-edge and polarity across the sixteen pins. It drives pad patterns that create rising and falling edges on all pins at once. If a design swapped the polarity or ignored the both-edge bit, some pins would latch the wrong edge, and raw status would differ from the arithmetic model. Level pins are checked after a full acknowledge: a design that latched level events would keep stale bits, or lose live ones. The bench lines up an edge with an acknowledge in the same cycle; a design where the clear wins would drop that interrupt. Mask-gated writes, direction-driven changes to input enable, and the two-cycle read latency are each checked. A wrong write mask would corrupt protected outputs. A wrong input-enable update would show a stale readback. A missing synchroniser stage would show the pad one cycle early.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

    localparam int REG_W  = 32;
    localparam int ADDR_W = 6;

    // Register byte offsets (software-visible map)
    localparam logic [ADDR_W-1:0] OFS_DATA  = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_AMASK = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_DIR   = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_SENSE = 6'h0C;
    localparam logic [ADDR_W-1:0] OFS_DUAL  = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_POLAR = 6'h14;
    localparam logic [ADDR_W-1:0] OFS_IEN   = 6'h18;
    localparam logic [ADDR_W-1:0] OFS_RAW   = 6'h1C;
    localparam logic [ADDR_W-1:0] OFS_MSK   = 6'h20;
    localparam logic [ADDR_W-1:0] OFS_ACK   = 6'h24;
    localparam logic [ADDR_W-1:0] OFS_RXEN  = 6'h28;

    typedef enum logic [0:0] {
        DET_IDLE = 1'b0,
        DET_HELD = 1'b1
    } det_state_e;

    typedef struct packed {
        logic level;   // 1: level sensing, 0: edge sensing
        logic dual;    // edge mode: trigger on both edges
        logic polar;   // 1: rising / active-high
    } sense_cfg_t;

endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= async_in;
            stab_q <= meta_q;
        end
    end

    assign sync_out = stab_q;
endmodule

// File: rtl/pinbank_detect.sv
module pinbank_detect
    import pinbank_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lvl,
    input  sense_cfg_t cfg,
    input  logic       ack,
    output logic       raw
);
    det_state_e state_q, state_d;
    logic       prev_q;
    logic       rise, fall, trig;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;
    assign fall = ~lvl & prev_q;

    always_comb begin
        if (cfg.level)     trig = 1'b0;
        else if (cfg.dual) trig = rise | fall;
        else               trig = cfg.polar ? rise : fall;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DET_IDLE;
        else        state_q <= state_d;
    end

    // Next state: ARM on trigger, RELEASE on ack without a fresh trigger
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DET_IDLE: if (trig)        state_d = DET_HELD;
            DET_HELD: if (ack && !trig) state_d = DET_IDLE;
            default:                   state_d = DET_IDLE;
        endcase
    end

    // Output
    always_comb begin
        if (cfg.level) raw = cfg.polar ? lvl : ~lvl;
        else           raw = (state_q == DET_HELD);
    end
endmodule

// File: rtl/pinbank_regs.sv
module pinbank_regs
    import pinbank_pkg::*;
#(
    parameter int PINS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [PINS-1:0]   wdata,
    output logic [REG_W-1:0]  rdata,
    input  logic [PINS-1:0]   pin_lvl,
    input  logic [PINS-1:0]   raw,
    output logic [PINS-1:0]   dir_q,
    output logic [PINS-1:0]   outv_q,
    output logic [PINS-1:0]   amask_q,
    output logic [PINS-1:0]   ien_q,
    output logic [PINS-1:0]   ack_stb,
    output sense_cfg_t        cfg [PINS]
);
    localparam int PAD_W = REG_W - PINS;

    logic [PINS-1:0] rxen_q, sense_q, dual_q, polar_q;
    logic [PINS-1:0] dir_flip;
    logic [PINS-1:0] rd_val;

    assign dir_flip = dir_q ^ wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q   <= '0;
            outv_q  <= '0;
            amask_q <= '0;
            ien_q   <= '0;
            rxen_q  <= '0;
            sense_q <= '0;
            dual_q  <= '0;
            polar_q <= '0;
        end else if (we) begin
            case (addr)
                OFS_DATA:  outv_q  <= (outv_q & ~amask_q) | (wdata & amask_q);
                OFS_AMASK: amask_q <= wdata;
                OFS_DIR: begin
                    dir_q  <= wdata;
                    rxen_q <= (rxen_q & ~dir_flip) | (~wdata & dir_flip);
                end
                OFS_SENSE: sense_q <= wdata;
                OFS_DUAL:  dual_q  <= wdata;
                OFS_POLAR: polar_q <= wdata;
                OFS_IEN:   ien_q   <= wdata;
                OFS_RXEN:  rxen_q  <= wdata;
                default: ;
            endcase
        end
    end

    assign ack_stb = (we && addr == OFS_ACK) ? wdata : '0;

    for (genvar i = 0; i < PINS; i++) begin : g_cfg
        assign cfg[i] = '{level: sense_q[i], dual: dual_q[i], polar: polar_q[i]};
    end

    always_comb begin
        case (addr)
            OFS_DATA:  rd_val = pin_lvl & rxen_q & amask_q;
            OFS_AMASK: rd_val = amask_q;
            OFS_DIR:   rd_val = dir_q;
            OFS_SENSE: rd_val = sense_q;
            OFS_DUAL:  rd_val = dual_q;
            OFS_POLAR: rd_val = polar_q;
            OFS_IEN:   rd_val = ien_q;
            OFS_RAW:   rd_val = raw;
            OFS_MSK:   rd_val = raw & ien_q;
            OFS_RXEN:  rd_val = rxen_q;
            default:   rd_val = '0;
        endcase
    end

    assign rdata = {{PAD_W{1'b0}}, rd_val};
endmodule

// File: rtl/pinbank_irq.sv
module pinbank_irq
    import pinbank_pkg::*;
#(
    parameter int PINS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [PINS-1:0]   pad_in,
    output logic [PINS-1:0]   pad_oe,
    output logic [PINS-1:0]   pad_out,
    output logic              irq_out
);
    logic [PINS-1:0] lvl_w, raw_w, ie_w, dmsk_w, dir_w, outv_w, ack_w;
    sense_cfg_t      cfg_w [PINS];
    logic            irq_q;

    pinbank_sync #(.W(PINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (lvl_w)
    );

    pinbank_regs #(.PINS(PINS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (reg_addr),
        .we      (reg_we),
        .wdata   (reg_wdata[PINS-1:0]),
        .rdata   (reg_rdata),
        .pin_lvl (lvl_w),
        .raw     (raw_w),
        .dir_q   (dir_w),
        .outv_q  (outv_w),
        .amask_q (dmsk_w),
        .ien_q   (ie_w),
        .ack_stb (ack_w),
        .cfg     (cfg_w)
    );

    for (genvar i = 0; i < PINS; i++) begin : g_pin
        pinbank_detect u_det (
            .clk   (clk),
            .rst_n (rst_n),
            .lvl   (lvl_w[i]),
            .cfg   (cfg_w[i]),
            .ack   (ack_w[i]),
            .raw   (raw_w[i])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(raw_w & ie_w);
    end

    assign pad_oe  = dir_w;
    assign pad_out = outv_w;
    assign irq_out = irq_q;
endmodule

// File: rtl/pinbank_irq_chk.sv
module pinbank_irq_chk
    import pinbank_pkg::*;
#(
    parameter int PINS = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_we,
    input logic [REG_W-1:0]  reg_wdata,
    input logic [REG_W-1:0]  reg_rdata,
    input logic [PINS-1:0]   pad_oe,
    input logic [PINS-1:0]   pad_out,
    input logic              irq_out,
    input logic [PINS-1:0]   dmsk,
    input logic [PINS-1:0]   ie,
    input logic [PINS-1:0]   raw
);
    p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[REG_W-1:PINS] == '0);

    p_dir_drives_oe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == OFS_DIR) |=> pad_oe == $past(reg_wdata[PINS-1:0]));

    p_oe_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_addr == OFS_DIR) |=> $stable(pad_oe));

    p_masked_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == OFS_DATA) |=>
            ((pad_out ^ $past(pad_out)) & ~$past(dmsk)) == '0);

    p_irq_or_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> irq_out == $past(|(raw & ie)));
endmodule

bind pinbank_irq pinbank_irq_chk #(.PINS(PINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out),
    .irq_out   (irq_out),
    .dmsk      (dmsk_w),
    .ie        (ie_w),
    .raw       (raw_w)
);

// File: tb/pinbank_irq_test.sv
`timescale 1ns/1ps
module pinbank_irq_test;
    import pinbank_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic              reg_we = 1'b0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic [15:0]       pad_in = '0;
    logic [15:0]       pad_oe, pad_out;
    logic              irq_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    pinbank_irq uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out), .irq_out(irq_out)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Bench model state for interrupt sweep
    logic [15:0] m_sense, m_dual, m_polar, m_ie, m_pend, m_last;

    function automatic logic [15:0] model_raw(input logic [15:0] pat);
        logic [15:0] r = '0;
        for (int i = 0; i < 16; i++) begin
            logic up, dn, hit;
            up  = pat[i] & ~m_last[i];
            dn  = ~pat[i] & m_last[i];
            hit = m_dual[i] ? (up | dn) : (m_polar[i] ? up : dn);
            if (!m_sense[i] && hit) m_pend[i] = 1'b1;
            r[i] = m_sense[i] ? (m_polar[i] ? pat[i] : ~pat[i]) : m_pend[i];
        end
        return r;
    endfunction

    task automatic apply_pat(input logic [15:0] pat);
        logic [31:0] v;
        logic [15:0] er;
        @(negedge clk);
        pad_in = pat;
        step(4);
        er = model_raw(pat);
        m_last = pat;
        rd(OFS_RAW, v);  check("R6/R7/R8 raw status sweep", v, {16'h0, er});
        rd(OFS_MSK, v);  check("R10 masked status", v, {16'h0, er & m_ie});
        check("R10 irq_out", {31'h0, irq_out}, {31'h0, |(er & m_ie)});
        wr(OFS_ACK, 32'h0000_FFFF);
        m_pend = '0;
        step(2);
        er = model_raw(pat);
        rd(OFS_RAW, v);  check("R8/R9 raw after full ack", v, {16'h0, er});
        check("R10 irq_out after ack", {31'h0, irq_out}, {31'h0, |(er & m_ie)});
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        step(3);
        rst_n = 1'b1;
        step(2);

        // R1 reset state
        for (int a = 0; a <= 'h28; a += 4) begin
            rd(ADDR_W'(a), v);
            check("R1 reset register", v, 32'h0);
        end
        check("R1 reset pad_oe", {16'h0, pad_oe}, 32'h0);
        check("R1 reset pad_out", {16'h0, pad_out}, 32'h0);
        check("R1 reset irq_out", {31'h0, irq_out}, 32'h0);

        // R2 upper bits and read-only/write-only registers
        wr(OFS_AMASK, 32'hFFFF_FFFF);
        rd(OFS_AMASK, v); check("R2 upper bits zero", v, 32'h0000_FFFF);
        wr(OFS_RAW, 32'hFFFF_FFFF);
        wr(OFS_MSK, 32'hFFFF_FFFF);
        rd(OFS_RAW, v); check("R2 raw write ignored", v, 32'h0);
        rd(OFS_ACK, v); check("R2 ack reads zero", v, 32'h0);

        // R4 masked data writes
        wr(OFS_AMASK, 32'h0000_00FF);
        wr(OFS_DATA, 32'h0000_FFFF);
        check("R4 masked write low byte", {16'h0, pad_out}, 32'h0000_00FF);
        wr(OFS_AMASK, 32'h0000_FFFF);
        wr(OFS_DATA, 32'h0000_1234);
        check("R4 full write", {16'h0, pad_out}, 32'h0000_1234);
        wr(OFS_AMASK, 32'h0000_F0F0);
        wr(OFS_DATA, 32'h0000_0000);
        check("R4 partial clear", {16'h0, pad_out}, 32'h0000_0204);

        // R3 direction and input-enable coupling
        wr(OFS_DIR, 32'h0000_FFFF);
        check("R3 pad_oe all out", {16'h0, pad_oe}, 32'h0000_FFFF);
        rd(OFS_RXEN, v); check("R3 rxen cleared on output", v, 32'h0);
        wr(OFS_RXEN, 32'h0000_00FF);
        wr(OFS_DIR, 32'h0000_0F0F);
        check("R3 pad_oe mixed", {16'h0, pad_oe}, 32'h0000_0F0F);
        rd(OFS_RXEN, v); check("R3 rxen set on input, kept if unchanged", v, 32'h0000_F0FF);

        // R5 data read gating and latency
        wr(OFS_RXEN, 32'h0000_FFFF);
        wr(OFS_AMASK, 32'h0000_0FF0);
        @(negedge clk); pad_in = 16'hABCD;
        step(3);
        rd(OFS_DATA, v); check("R5 read masked", v, 32'h0000_0BC0);
        wr(OFS_RXEN, 32'h0000_00FF);
        rd(OFS_DATA, v); check("R5 read rxen gated", v, 32'h0000_00C0);
        wr(OFS_AMASK, 32'h0000_FFFF);
        wr(OFS_RXEN, 32'h0000_FFFF);
        reg_addr = OFS_DATA;
        @(negedge clk); pad_in = 16'h0000;
        @(negedge clk); #1 check("R5 one edge still old", reg_rdata, 32'h0000_ABCD);
        @(negedge clk); #1 check("R5 two edges new", reg_rdata, 32'h0000_0000);
        step(2);

        // Interrupt mode sweep, two polarity sets
        for (int pass = 0; pass < 2; pass++) begin
            for (int i = 0; i < 16; i++) begin
                m_sense[i] = i[0];
                m_dual[i]  = i[1];
                m_polar[i] = i[2] ^ pass[0];
            end
            m_ie = (pass == 0) ? 16'hFFFF : 16'h0F0F;
            wr(OFS_SENSE, {16'h0, m_sense});
            wr(OFS_DUAL,  {16'h0, m_dual});
            wr(OFS_POLAR, {16'h0, m_polar});
            wr(OFS_IEN,   {16'h0, m_ie});
            wr(OFS_ACK, 32'h0000_FFFF);
            m_pend = '0;
            m_last = pad_in;
            step(2);
            apply_pat(16'hFFFF);
            apply_pat(16'h0000);
            apply_pat(16'hA5A5);
            apply_pat(16'h5A5A);
            apply_pat(16'hFFFF);
        end

        // R10 fully masked: no irq
        wr(OFS_IEN, 32'h0);
        wr(OFS_SENSE, 32'h0000_FFFF);
        wr(OFS_POLAR, 32'h0000_FFFF);
        step(2);
        rd(OFS_RAW, v); check("R8 level active high all set", v, 32'h0000_FFFF);
        check("R10 irq low when all masked", {31'h0, irq_out}, 32'h0);

        // R6/R9 rising-only, ack-0 and partial ack
        wr(OFS_SENSE, 32'h0);
        wr(OFS_DUAL, 32'h0);
        wr(OFS_POLAR, 32'h0000_FFFF);
        @(negedge clk); pad_in = 16'h0000;
        step(4);
        wr(OFS_ACK, 32'h0000_FFFF);
        rd(OFS_RAW, v); check("R6 falling ignored when rising selected", v, 32'h0);
        @(negedge clk); pad_in = 16'h00FF;
        step(4);
        rd(OFS_RAW, v); check("R6 rising latched", v, 32'h0000_00FF);
        wr(OFS_ACK, 32'h0);
        rd(OFS_RAW, v); check("R9 ack zero no effect", v, 32'h0000_00FF);
        wr(OFS_ACK, 32'h0000_000F);
        rd(OFS_RAW, v); check("R9 partial ack", v, 32'h0000_00F0);
        wr(OFS_ACK, 32'h0000_FFFF);

        // R9 edge in same cycle as ack keeps the bit set
        @(negedge clk); pad_in = 16'h01FF;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        reg_addr = OFS_ACK; reg_wdata = 32'h0000_FFFF; reg_we = 1'b1;
        @(negedge clk); reg_we = 1'b0;
        rd(OFS_RAW, v); check("R9 edge wins over same-cycle ack", v, 32'h0000_0100);
        wr(OFS_ACK, 32'h0000_FFFF);
        rd(OFS_RAW, v); check("R9 later ack clears", v, 32'h0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule